// File: doc/BRIEF.md
# I2C Repeated-Start Generator

This block is the part of an I2C master that places a repeated-start condition on an open-drain bus. A request pulse from the surrounding master, together with a reload value for an internal down-counter, starts a fixed sequence of bus phases. Each phase lasts one bus timing unit of reload+1 system clocks. The block pulls SCL low and releases SDA. It then releases SCL, and with both lines high it pulls SDA low to form the start edge. Finally it pulls SCL low again and leaves SDA held low, ready for the first data bit.

The block never trusts its own drive. Each phase waits until the synchronized pin reads the new level before the counter begins that phase, so a slave stretching SCL simply delays the sequence. SDA and SCL pass through two-flop synchronizers. The block watches for another master in two places. A collision aborts the sequence, releases both lines and reports the collision instead of completion. A request that arrives while the master is busy with another event, or while this sequence is already running, is dropped.

Top module: `i2c_rstart_gen`

## Requirements
- R1: A request pulse is ignored when `busy_i` is high or a sequence is already in progress. `req_o` and both pull enables keep their values, and a running sequence keeps its timing.
- R2: An accepted request sets `req_o`, asserts `scl_pull_o` and clears `sda_pull_o` at the accepting edge. The counter is loaded at the first edge at which synchronized SCL reads low, which is the third edge after the accept when SCL was high (two synchronizer flops).
- R3: One timing unit is reload+1 clocks. With SCL low, SCL is released at the first timeout edge at which synchronized SDA reads high. From a bus that starts released, this is reload+4 clocks after the accept.
- R4: After SCL is released, the counter holds until synchronized SCL reads high. Holding SCL low for S extra clocks delays every later event by exactly S clocks.
- R5: With both lines high for one timing unit, SDA is pulled low. From a released bus this is 2*reload+8+S clocks after the accept, and `sda_pull_o` stays low in all earlier phases.
- R6: One timing unit after SDA is pulled low (3*reload+9+S clocks from a released bus), `done_o` pulses for exactly one clock. In the same edge `scl_pull_o` asserts and `req_o` clears, and `sda_pull_o` stays asserted afterwards.
- R7: `start_seen_o` sets one clock after synchronized SDA falls while synchronized SCL is high (2*reload+11+S clocks from a released bus), and clears on the next accepted request.
- R8: If synchronized SDA reads low at the edge where synchronized SCL is first seen high after release, a collision is taken.
- R9: If synchronized SCL reads low at any edge of the both-high phase, including its timeout edge, a collision is taken and SDA is never pulled.
- R10: A collision gives a one-clock `coll_o` pulse, clears `req_o`, deasserts both pull enables and returns to idle without `done_o`.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_set_i | input | 1 | One-clock request pulse |
| busy_i | input | 1 | Another master event is active |
| reload_i | input | RW | Counter reload value |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_pull_o | output | 1 | Pull SDA low when high |
| scl_pull_o | output | 1 | Pull SCL low when high |
| req_o | output | 1 | Request bit, cleared by the block |
| done_o | output | 1 | Completion pulse |
| start_seen_o | output | 1 | Start condition observed on the bus |
| coll_o | output | 1 | Bus collision pulse |

## Verification
A wrong phase state or a counter off by one shows up directly as a shifted release edge, pull edge or completion pulse. Each of these edges is timed against a cycle number computed from the reload value and the stretch length, so the error is caught within one timing unit of where it happens. A collision check that is missing or placed at the wrong time shows up as a completion pulse where `coll_o` was expected, or as an asserted SDA pull. A request that is not properly rejected shows up as `req_o` or SCL pull activity in the following clocks.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SCL_LO,
    ST_SDA_REL,
    ST_WAIT_SCL_HI,
    ST_BOTH_HI,
    ST_SDA_LOW
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle bus reads high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [RW-1:0] reload_i,
  output logic          zero_o
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= reload_i;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4: counter frozen outside counting phases (clock stretch wait)
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen
  import i2c_rs_pkg::*;
#(
  parameter int RW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_set_i,
  input  logic          busy_i,
  input  logic [RW-1:0] reload_i,
  input  logic          sda_i,
  input  logic          scl_i,
  output logic          sda_pull_o,
  output logic          scl_pull_o,
  output logic          req_o,
  output logic          done_o,
  output logic          start_seen_o,
  output logic          coll_o
);
  rs_state_e state_q;
  logic sda_s, scl_s, sda_prev_q;
  logic brg_load, brg_run, brg_zero, accept;

  i2c_rs_sync #(.STAGES(SYNC_LEN)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));
  i2c_rs_sync #(.STAGES(SYNC_LEN)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));

  assign accept = (state_q == ST_IDLE) && req_set_i && !busy_i;

  always_comb begin
    brg_load = 1'b0;
    unique case (state_q)
      ST_WAIT_SCL_LO: brg_load = !scl_s;
      ST_WAIT_SCL_HI: brg_load = scl_s && sda_s;
      ST_BOTH_HI:     brg_load = scl_s && brg_zero;
      default:        brg_load = 1'b0;
    endcase
  end

  assign brg_run = (state_q == ST_SDA_REL) || (state_q == ST_BOTH_HI) ||
                   (state_q == ST_SDA_LOW);

  i2c_rs_brg #(.RW(RW)) u_brg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(brg_load), .run_i(brg_run),
    .reload_i(reload_i), .zero_o(brg_zero));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sda_pull_o <= 1'b0;
      scl_pull_o <= 1'b0;
      req_o      <= 1'b0;
      done_o     <= 1'b0;
      coll_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      coll_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          req_o      <= 1'b1;
          scl_pull_o <= 1'b1;
          sda_pull_o <= 1'b0;
          state_q    <= ST_WAIT_SCL_LO;
        end
        ST_WAIT_SCL_LO: if (!scl_s) state_q <= ST_SDA_REL;
        ST_SDA_REL: if (brg_zero && sda_s) begin
          scl_pull_o <= 1'b0;
          state_q    <= ST_WAIT_SCL_HI;
        end
        ST_WAIT_SCL_HI: if (scl_s) begin
          if (!sda_s) begin  // SDA low at SCL rise
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            req_o      <= 1'b0;
            coll_o     <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_BOTH_HI;
          end
        end
        ST_BOTH_HI: begin
          if (!scl_s) begin  // SCL dropped before our SDA pull
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            req_o      <= 1'b0;
            coll_o     <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (brg_zero) begin
            sda_pull_o <= 1'b1;
            state_q    <= ST_SDA_LOW;
          end
        end
        ST_SDA_LOW: if (brg_zero) begin
          scl_pull_o <= 1'b1;
          req_o      <= 1'b0;
          done_o     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_prev_q   <= 1'b1;
      start_seen_o <= 1'b0;
    end else begin
      sda_prev_q <= sda_s;
      if (accept)                               start_seen_o <= 1'b0;
      else if (sda_prev_q && !sda_s && scl_s)   start_seen_o <= 1'b1;
    end
  end

  a_r1_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_set_i && busy_i) |=>
      (state_q == ST_IDLE && !req_o && scl_pull_o == $past(scl_pull_o)));
  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> req_o);
  a_r5_no_early_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SDA_REL || state_q == ST_WAIT_SCL_HI || state_q == ST_BOTH_HI)
      |-> !sda_pull_o);
  a_r6_done_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scl_pull_o && sda_pull_o && !req_o && !coll_o));
  a_r6_done_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q == ST_SDA_LOW));
  a_r10_coll_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> (!scl_pull_o && !sda_pull_o && !req_o && state_q == ST_IDLE));
endmodule

// File: tb/i2c_rstart_gen_tb_top.sv
module i2c_rstart_gen_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_set_i = 1'b0, busy_i = 1'b0;
  logic [7:0] reload_i = '0;
  logic ext_sda = 1'b0, ext_scl = 1'b0;
  logic sda_pull_o, scl_pull_o, req_o, done_o, start_seen_o, coll_o;
  logic sda_line, scl_line;
  int cyc = 0, n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = !(sda_pull_o || ext_sda);
  assign scl_line = !(scl_pull_o || ext_scl);

  i2c_rstart_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_set_i(req_set_i), .busy_i(busy_i),
    .reload_i(reload_i), .sda_i(sda_line), .scl_i(scl_line),
    .sda_pull_o(sda_pull_o), .scl_pull_o(scl_pull_o), .req_o(req_o),
    .done_o(done_o), .start_seen_o(start_seen_o), .coll_o(coll_o));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected offsets from the accepting edge; b=2 when the bus was left pulled
  function automatic int exp_rel(int r, int b);  return 4 + r - b; endfunction
  function automatic int exp_pull(int r, int s, int b); return 8 + 2*r + s - b; endfunction
  function automatic int exp_done(int r, int s, int b); return 9 + 3*r + s - b; endfunction
  function automatic int exp_ss(int r, int s, int b);   return 11 + 2*r + s - b; endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; ext_sda = 1'b0; ext_scl = 1'b0; req_set_i = 1'b0; busy_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_seq(int r, int s, bit warm);
    int e0, left, b;
    int t_rel = -1, t_pull = -1, t_done = -1, t_ss = -1, n_done = 0, n_coll = 0;
    bit seen = 0;
    b = warm ? 2 : 0;
    reload_i = 8'(r);
    req_set_i = 1'b1; e0 = cyc + 1;
    @(negedge clk);
    req_set_i = 1'b0;
    chk(req_o == 1'b1 && scl_pull_o && !sda_pull_o, "R2 accept", int'(req_o), 1);
    chk(start_seen_o == 1'b0, "R7 clear on accept", int'(start_seen_o), 0);
    if (s > 0) ext_scl = 1'b1;
    for (int k = 0; k < 3*r + s + 30; k++) begin
      req_set_i = (cyc == e0 + 2);  // R1: request while active
      if (!seen && !scl_pull_o) begin
        seen = 1; t_rel = cyc - e0; left = s;
        if (left == 0) ext_scl = 1'b0;
      end else if (seen && left > 0) begin
        left--;
        if (left == 0) ext_scl = 1'b0;
      end
      if (t_pull < 0 && sda_pull_o) t_pull = cyc - e0;
      if (done_o) begin n_done++; if (t_done < 0) t_done = cyc - e0; end
      if (coll_o) n_coll++;
      if (t_ss < 0 && start_seen_o) t_ss = cyc - e0;
      @(negedge clk);
    end
    req_set_i = 1'b0;
    chk(t_rel == exp_rel(r, b), "R3 scl release", t_rel, exp_rel(r, b));
    chk(t_pull == exp_pull(r, s, b), "R4/R5 sda pull", t_pull, exp_pull(r, s, b));
    chk(t_done == exp_done(r, s, b), "R6 done time", t_done, exp_done(r, s, b));
    chk(n_done == 1 && n_coll == 0, "R6 R1 single done", n_done, 1);
    chk(!req_o && scl_pull_o && sda_pull_o, "R6 final lines",
        int'({req_o, scl_pull_o, sda_pull_o}), 3);
    chk(t_ss == exp_ss(r, s, b), "R7 start seen", t_ss, exp_ss(r, s, b));
  endtask

  task automatic coll_sda(int r);
    int e0, t_coll = -1, n_done = 0;
    bit seen = 0, rel_ok = 1;
    reload_i = 8'(r);
    req_set_i = 1'b1; e0 = cyc + 1;
    @(negedge clk);
    req_set_i = 1'b0;
    for (int k = 0; k < 3*r + 30; k++) begin
      if (!seen && !scl_pull_o) begin seen = 1; ext_sda = 1'b1; end
      if (coll_o && t_coll < 0) begin
        t_coll = cyc - e0;
        rel_ok = !scl_pull_o && !sda_pull_o && !req_o;
      end
      if (done_o) n_done++;
      @(negedge clk);
    end
    chk(t_coll == 7 + r, "R8 sda-low collision", t_coll, 7 + r);
    chk(rel_ok && n_done == 0 && !coll_o, "R10 collision outcome", n_done, 0);
    ext_sda = 1'b0;
  endtask

  task automatic coll_scl(int r);
    int e0, t_coll = -1, n_done = 0;
    bit pulled = 0, rel_ok = 1;
    reload_i = 8'(r);
    req_set_i = 1'b1; e0 = cyc + 1;
    @(negedge clk);
    req_set_i = 1'b0;
    for (int k = 0; k < 3*r + 30; k++) begin
      if (cyc - e0 == 8 + r) ext_scl = 1'b1;
      if (sda_pull_o) pulled = 1;
      if (coll_o && t_coll < 0) begin
        t_coll = cyc - e0;
        rel_ok = !scl_pull_o && !sda_pull_o && !req_o;
      end
      if (done_o) n_done++;
      @(negedge clk);
    end
    chk(t_coll == 11 + r, "R9 scl-low collision", t_coll, 11 + r);
    chk(!pulled, "R9 sda never pulled", int'(pulled), 0);
    chk(rel_ok && n_done == 0, "R10 collision outcome", n_done, 0);
    ext_scl = 1'b0;
  endtask

  initial begin
    int r, s, seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    do_reset();
    chk({sda_pull_o, scl_pull_o, req_o, done_o, start_seen_o, coll_o} == 6'b0,
        "R11 reset state", int'({sda_pull_o, scl_pull_o, req_o, done_o, start_seen_o, coll_o}), 0);

    // R1: busy reject
    busy_i = 1'b1; req_set_i = 1'b1;
    @(negedge clk);
    req_set_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(!req_o && !scl_pull_o, "R1 busy reject", int'({req_o, scl_pull_o}), 0);
    busy_i = 1'b0;

    // directed corners: minimum reload, boundary both-high collision
    do_reset(); run_seq(0, 0, 0);
    run_seq(1, 0, 1);
    do_reset(); coll_scl(3);
    do_reset(); coll_sda(0);

    for (int i = 0; i < 16; i++) begin
      r = int'($urandom_range(0, 12));
      s = int'($urandom_range(0, 6));
      do_reset();
      run_seq(r, s, 0);
      if (r > 0) run_seq(r, int'($urandom_range(0, 3)), 1);
    end
    for (int i = 0; i < 4; i++) begin
      do_reset(); coll_sda(int'($urandom_range(0, 10)));
      do_reset(); coll_scl(int'($urandom_range(3, 10)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule